// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block holds the address and count state of one memory-to-memory DMA channel. Software programs a source pointer, a destination pointer, a pair of function codes and a byte count through a small register port, then starts the channel. Each transfer is a read cycle from the source followed by a write cycle to the destination. For each cycle the engine drives the bus address, the 3-bit function code, the direction and the operand size. A bus-side sequencer runs the actual cycles and reports back through a completion strobe (`cyc_done`) and a bus error flag (`cyc_berr`).

After every completed write cycle the engine advances each pointer whose increment enable is set, by one for a byte or two for a word, and wraps at 24 bits. It also lowers the remaining count by the same number of bytes. When the count reaches zero the channel stops and flags completion. Bus errors stop the channel and are recorded separately for the source side and the destination side. A fourth event bit is latched from an external input. The four event bits are also presented on a port, so that interrupt logic alongside can decode them.

Top module: `dma_addr_engine`

## Requirements
- R1: After reset `ch_req` is 0, `evt_status` is 0 and the count, pointer and status registers read as 0.
- R2: Register port, selected by `reg_sel` and written when `reg_we` is 1. 0 is control, with bit0 run, bit1 word mode, bit2 source increment enable and bit3 destination increment enable. 1 is the source pointer, 2 the destination pointer, 3 the function codes, 4 the byte count and 5 the status. A control write takes effect at any time. Writing run=1 starts the channel in the read phase, and writing run=0 aborts it. `ch_req` mirrors run.
- R3: While running, the read phase has `bus_write`=0 and drives the source pointer and source code. The write phase has `bus_write`=1 and drives the destination pointer and destination code. A `cyc_done` without error in the read phase moves to the write phase, and in the write phase it completes the transfer and returns to the read phase.
- R4: On each completed transfer a pointer with its enable set advances by the transfer size, using unsigned 24-bit arithmetic (0xFFFFFF+1 gives 0x000000). A pointer with its enable clear holds its value.
- R5: In word mode a transfer is a word (`bus_word`=1, step 2, count minus 2) unless either pointer is odd or the remaining count is 1. Otherwise it is a byte (`bus_word`=0, step 1, count minus 1). In byte mode every transfer is a byte.
- R6: A programmed count of 0 moves 65536 bytes.
- R7: On the transfer whose count update reaches zero, status bit0 (done) is set and `ch_req` falls at the same clock edge.
- R8: `cyc_berr` with `cyc_done` in the read phase sets status bit2. In the write phase it sets status bit1. Either one stops the channel and leaves both pointers and the count unchanged.
- R9: A 1 on `dns_evt` sets status bit3 at the next edge.
- R10: Writing the status register clears each bit 3..0 written as 1 and leaves the bits written as 0. A set in the same cycle wins over a clear. Bits 7..4 always read 0.
- R11: Writes to the pointers, the count and the function codes are ignored while the channel runs.
- R12: The function code register holds the source code in bits 2..0 and the destination code in bits 6..4. Bits 3 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for `reg_sel` |
| ch_req | output | 1 | Channel running, requesting bus cycles |
| bus_addr | output | 24 | Address of the current cycle |
| bus_fc | output | 3 | Function code of the current cycle |
| bus_write | output | 1 | 0 for the read phase, 1 for the write phase |
| bus_word | output | 1 | 1 for a word operand, 0 for a byte operand |
| cyc_done | input | 1 | Current bus cycle has finished |
| cyc_berr | input | 1 | Current bus cycle ended in a bus error (qualified by `cyc_done`) |
| dns_evt | input | 1 | External event that sets status bit3 |
| evt_status | output | 8 | Status register contents |

## Verification
The bench builds the engine with its default widths: 24-bit pointers and a 16-bit counter. These widths bring the real wrap point 0xFFFFFF and the full 65536-byte job that a zero count encodes within reach. The 65536-byte job runs in word mode in about 65536 cycles, so the check of the last transfer is an exact one. Directed jobs start at odd addresses, end on an odd remainder, hit a bus error in each phase, and collide a status set with a clear.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

    localparam int FC_W     = 3;
    localparam int EVT_W    = 4;

    localparam int EV_DONE  = 0;
    localparam int EV_DERR  = 1;
    localparam int EV_SERR  = 2;
    localparam int EV_EXT   = 3;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_SRC  = 3'd1,
        SEL_DST  = 3'd2,
        SEL_FC   = 3'd3,
        SEL_CNT  = 3'd4,
        SEL_STAT = 3'd5
    } reg_sel_e;

    typedef enum logic {
        PH_RD = 1'b0,
        PH_WR = 1'b1
    } phase_e;

    typedef struct packed {
        logic            run;
        phase_e          phase;
        logic            word_mode;
        logic            src_inc;
        logic            dst_inc;
        logic [FC_W-1:0] sfc;
        logic [FC_W-1:0] dfc;
    } chan_ctl_t;

endpackage

// File: rtl/dmae_ptr.sv
module dmae_ptr #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic          inc_en,
    input  logic          step2,
    output logic [AW-1:0] ptr
);

    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = load_val;
        end else if (adv && inc_en) begin
            // unsigned add, natural wrap at AW bits
            ptr_d = ptr_q + (step2 ? AW'(2) : AW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/dmae_count.sv
module dmae_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          adv,
    input  logic          word_mode,
    input  logic          src_odd,
    input  logic          dst_odd,
    output logic [CW-1:0] cnt,
    output logic          take_word,
    output logic          last
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] cnt_next;

    // a stored zero stands for 2**CW bytes; only the decrement result is tested
    always_comb begin
        take_word = word_mode && !src_odd && !dst_odd && (cnt_q != CW'(1));
        cnt_next  = cnt_q - (take_word ? CW'(2) : CW'(1));
        last      = adv && (cnt_next == '0);
        cnt_d     = cnt_q;
        if (load)     cnt_d = load_val;
        else if (adv) cnt_d = cnt_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/dmae_status.sv
module dmae_status #(
    parameter int SW = 8,
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] set_evt,
    input  logic          clr_we,
    input  logic [EW-1:0] clr_mask,
    output logic [SW-1:0] status
);

    localparam int PADW = SW - EW;

    logic [EW-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_we) stat_d = stat_d & ~clr_mask;
        stat_d = stat_d | set_evt;          // set beats clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status = {{PADW{1'b0}}, stat_q};

endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
    import dmae_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int SW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_sel,
    input  logic [AW-1:0]   reg_wdata,
    output logic [AW-1:0]   reg_rdata,
    output logic            ch_req,
    output logic [AW-1:0]   bus_addr,
    output logic [FC_W-1:0] bus_fc,
    output logic            bus_write,
    output logic            bus_word,
    input  logic            cyc_done,
    input  logic            cyc_berr,
    input  logic            dns_evt,
    output logic [SW-1:0]   evt_status
);

    localparam int NPTR = 2;   // index 0 source, 1 destination

    chan_ctl_t ctl_d, ctl_q;

    logic [AW-1:0]    ptr_val [NPTR];
    logic [NPTR-1:0]  ptr_load;
    logic [NPTR-1:0]  ptr_inc;
    logic [CW-1:0]    cnt_val;
    logic             take_word;
    logic             cnt_last;
    logic             cnt_load;
    logic             adv;
    logic             cyc_ok;
    logic             cyc_err;
    logic             idle_wr;
    logic [EVT_W-1:0] set_evt;
    reg_sel_e         sel;

    assign sel     = reg_sel_e'(reg_sel);
    assign cyc_ok  = ctl_q.run && cyc_done && !cyc_berr;
    assign cyc_err = ctl_q.run && cyc_done && cyc_berr;
    assign adv     = cyc_ok && (ctl_q.phase == PH_WR);
    assign idle_wr = reg_we && !ctl_q.run;

    // channel control: phase sequencing and programmed fields
    always_comb begin
        ctl_d = ctl_q;
        if (cyc_err) begin
            ctl_d.run = 1'b0;
        end else if (cyc_ok) begin
            if (ctl_q.phase == PH_RD) begin
                ctl_d.phase = PH_WR;
            end else begin
                ctl_d.phase = PH_RD;
                if (cnt_last) ctl_d.run = 1'b0;
            end
        end
        if (idle_wr && sel == SEL_FC) begin
            ctl_d.sfc = reg_wdata[FC_W-1:0];
            ctl_d.dfc = reg_wdata[FC_W+3:4];
        end
        if (reg_we && sel == SEL_CTRL) begin
            ctl_d.run       = reg_wdata[0];
            ctl_d.word_mode = reg_wdata[1];
            ctl_d.src_inc   = reg_wdata[2];
            ctl_d.dst_inc   = reg_wdata[3];
            ctl_d.phase     = PH_RD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ptr_load[0] = idle_wr && sel == SEL_SRC;
    assign ptr_load[1] = idle_wr && sel == SEL_DST;
    assign ptr_inc[0]  = ctl_q.src_inc;
    assign ptr_inc[1]  = ctl_q.dst_inc;
    assign cnt_load    = idle_wr && sel == SEL_CNT;

    for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
        dmae_ptr #(.AW(AW)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ptr_load[gi]),
            .load_val (reg_wdata),
            .adv      (adv),
            .inc_en   (ptr_inc[gi]),
            .step2    (take_word),
            .ptr      (ptr_val[gi])
        );
    end

    dmae_count #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_val  (reg_wdata[CW-1:0]),
        .adv       (adv),
        .word_mode (ctl_q.word_mode),
        .src_odd   (ptr_val[0][0]),
        .dst_odd   (ptr_val[1][0]),
        .cnt       (cnt_val),
        .take_word (take_word),
        .last      (cnt_last)
    );

    always_comb begin
        set_evt          = '0;
        set_evt[EV_DONE] = cnt_last;
        set_evt[EV_DERR] = cyc_err && (ctl_q.phase == PH_WR);
        set_evt[EV_SERR] = cyc_err && (ctl_q.phase == PH_RD);
        set_evt[EV_EXT]  = dns_evt;
    end

    dmae_status #(.SW(SW), .EW(EVT_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (set_evt),
        .clr_we   (reg_we && sel == SEL_STAT),
        .clr_mask (reg_wdata[EVT_W-1:0]),
        .status   (evt_status)
    );

    assign ch_req    = ctl_q.run;
    assign bus_write = (ctl_q.phase == PH_WR);
    assign bus_addr  = bus_write ? ptr_val[1] : ptr_val[0];
    assign bus_fc    = bus_write ? ctl_q.dfc : ctl_q.sfc;
    assign bus_word  = take_word;

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CTRL: reg_rdata = AW'({ctl_q.dst_inc, ctl_q.src_inc,
                                       ctl_q.word_mode, ctl_q.run});
            SEL_SRC:  reg_rdata = ptr_val[0];
            SEL_DST:  reg_rdata = ptr_val[1];
            SEL_FC:   reg_rdata = AW'({1'b0, ctl_q.dfc, 1'b0, ctl_q.sfc});
            SEL_CNT:  reg_rdata = AW'(cnt_val);
            SEL_STAT: reg_rdata = AW'(evt_status);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmae_checker.sv
module dmae_checker #(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int SW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic          ch_req,
    input logic          bus_write,
    input logic          bus_word,
    input logic [AW-1:0] bus_addr,
    input logic          cyc_done,
    input logic          cyc_berr,
    input logic          dns_evt,
    input logic [SW-1:0] evt_status,
    input logic [AW-1:0] src_ptr,
    input logic [AW-1:0] dst_ptr,
    input logic [CW-1:0] cnt
);

    // R3: an error-free read cycle leads into the write phase
    assert_rd_to_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_req && !bus_write && cyc_done && !cyc_berr && !reg_we) |=> (ch_req && bus_write));

    // R5: the count drops by the operand size of the finished transfer
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_req && bus_write && cyc_done && !cyc_berr && !reg_we)
        |=> (cnt == $past(cnt) - ($past(bus_word) ? CW'(2) : CW'(1))));

    // R5: a word operand never sits on an odd address
    assert_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_req && bus_word) |-> !bus_addr[0]);

    // R7: completion flag and request drop together
    assert_done_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_status[0]) |-> !ch_req);

    // R8: a bus error stops the channel and freezes the pointers and count
    assert_err_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_req && cyc_done && cyc_berr && !reg_we)
        |=> (!ch_req && $stable(src_ptr) && $stable(dst_ptr) && $stable(cnt)));

    // R9: the external event always lands in bit3
    assert_ext_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dns_evt |=> evt_status[3]);

    // R10: reserved status bits stay zero
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_status[SW-1:4] == '0);

endmodule

bind dma_addr_engine dmae_checker #(.AW(AW), .CW(CW), .SW(SW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .ch_req     (ch_req),
    .bus_write  (bus_write),
    .bus_word   (bus_word),
    .bus_addr   (bus_addr),
    .cyc_done   (cyc_done),
    .cyc_berr   (cyc_berr),
    .dns_evt    (dns_evt),
    .evt_status (evt_status),
    .src_ptr    (ptr_val[0]),
    .dst_ptr    (ptr_val[1]),
    .cnt        (cnt_val)
);

// File: tb/dma_addr_engine_tb.sv
module dma_addr_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        ch_req;
    logic [23:0] bus_addr;
    logic [2:0]  bus_fc;
    logic        bus_write;
    logic        bus_word;
    logic        cyc_done = 1'b0;
    logic        cyc_berr = 1'b0;
    logic        dns_evt = 1'b0;
    logic [7:0]  evt_status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    dma_addr_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_req(ch_req),
        .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_write(bus_write),
        .bus_word(bus_word), .cyc_done(cyc_done), .cyc_berr(cyc_berr),
        .dns_evt(dns_evt), .evt_status(evt_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [2:0] s, input logic [23:0] v);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [23:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic bus_cyc(input logic err);
        cyc_done = 1'b1; cyc_berr = err;
        @(negedge clk);
        cyc_done = 1'b0; cyc_berr = 1'b0;
    endtask

    task automatic setup(input logic [23:0] s, input logic [23:0] d, input logic [23:0] n);
        wr(3'd1, s); wr(3'd2, d); wr(3'd4, n);
    endtask

    task automatic t_reset;
        logic [23:0] v;
        chk("R1 ch_req", ch_req, 0);
        chk("R1 evt_status", evt_status, 0);
        rd(3'd4, v); chk("R1 count", v, 0);
        rd(3'd1, v); chk("R1 src", v, 0);
        rd(3'd5, v); chk("R1 status reg", v, 0);
    endtask

    task automatic t_fc_layout;
        logic [23:0] v;
        wr(3'd3, 24'hFF);
        rd(3'd3, v); chk("R12 fc mask", v, 24'h77);
        wr(3'd3, 24'h52);
        rd(3'd3, v); chk("R12 fc readback", v, 24'h52);
    endtask

    task automatic t_word_copy;
        logic [23:0] v;
        setup(24'h000100, 24'h000200, 24'd5);
        wr(3'd0, 24'hF);
        rd(3'd0, v); chk("R2 ctrl readback", v, 24'hF);
        chk("R2 req", ch_req, 1);
        chk("R3 rd dir", bus_write, 0);
        chk("R3 rd addr", bus_addr, 24'h100);
        chk("R3 rd fc", bus_fc, 3'd2);
        chk("R5 word", bus_word, 1);
        bus_cyc(0);
        chk("R3 wr dir", bus_write, 1);
        chk("R3 wr addr", bus_addr, 24'h200);
        chk("R3 wr fc", bus_fc, 3'd5);
        bus_cyc(0);
        chk("R4 src +2", bus_addr, 24'h102);
        rd(3'd4, v); chk("R5 cnt -2", v, 24'd3);
        bus_cyc(0); bus_cyc(0);
        chk("R5 last byte", bus_word, 0);
        chk("R4 src", bus_addr, 24'h104);
        bus_cyc(0);
        chk("R4 dst", bus_addr, 24'h204);
        bus_cyc(0);
        chk("R7 stop", ch_req, 0);
        chk("R7 done", evt_status, 8'h01);
        rd(3'd1, v); chk("R4 src final", v, 24'h105);
        rd(3'd4, v); chk("R7 cnt zero", v, 0);
        wr(3'd5, 24'hF);
    endtask

    task automatic t_odd_start;
        logic [23:0] v;
        setup(24'h000301, 24'h000400, 24'd4);
        wr(3'd0, 24'hF);
        chk("R5 odd src byte", bus_word, 0);
        bus_cyc(0); bus_cyc(0);
        rd(3'd1, v); chk("R5 src +1", v, 24'h302);
        rd(3'd2, v); chk("R5 dst +1", v, 24'h401);
        rd(3'd4, v); chk("R5 cnt -1", v, 24'd3);
        chk("R5 odd dst byte", bus_word, 0);
        wr(3'd0, 24'h0);
        chk("R2 abort", ch_req, 0);
        chk("R2 abort no done", evt_status, 0);
    endtask

    task automatic t_wrap;
        logic [23:0] v;
        setup(24'hFFFFFE, 24'h000050, 24'd4);
        wr(3'd0, 24'h7);
        chk("R5 word at wrap", bus_word, 1);
        bus_cyc(0); bus_cyc(0);
        rd(3'd1, v); chk("R4 wrap word", v, 24'h000000);
        rd(3'd2, v); chk("R4 dst held", v, 24'h000050);
        bus_cyc(0); bus_cyc(0);
        rd(3'd1, v); chk("R4 after wrap", v, 24'h000002);
        chk("R7 done wrap job", ch_req, 0);
        wr(3'd5, 24'hF);
        setup(24'hFFFFFF, 24'h000060, 24'd2);
        wr(3'd0, 24'h5);
        chk("R5 byte mode", bus_word, 0);
        bus_cyc(0); bus_cyc(0);
        rd(3'd1, v); chk("R4 wrap byte", v, 24'h000000);
        chk("R7 still running", ch_req, 1);
        bus_cyc(0); bus_cyc(0);
        chk("R7 done byte job", evt_status, 8'h01);
        wr(3'd5, 24'hF);
    endtask

    task automatic t_full_count;
        logic [23:0] v;
        setup(24'h000000, 24'h800000, 24'd0);
        wr(3'd0, 24'hF);
        cyc_done = 1'b1;
        repeat (2 * 32767) @(negedge clk);
        cyc_done = 1'b0;
        chk("R6 running before last", ch_req, 1);
        chk("R6 no early done", evt_status, 0);
        rd(3'd4, v); chk("R6 cnt before last", v, 24'd2);
        bus_cyc(0); bus_cyc(0);
        chk("R6 done after 65536", evt_status, 8'h01);
        rd(3'd1, v); chk("R6 src end", v, 24'h010000);
        wr(3'd5, 24'hF);
    endtask

    task automatic t_bus_err;
        logic [23:0] v;
        setup(24'h000010, 24'h000020, 24'd8);
        wr(3'd0, 24'hF);
        bus_cyc(1);
        chk("R8 src err stop", ch_req, 0);
        chk("R8 src err bit", evt_status, 8'h04);
        rd(3'd1, v); chk("R8 src held", v, 24'h10);
        rd(3'd4, v); chk("R8 cnt held", v, 24'd8);
        wr(3'd5, 24'hF);
        wr(3'd0, 24'hF);
        bus_cyc(0);
        bus_cyc(1);
        chk("R8 dst err stop", ch_req, 0);
        chk("R8 dst err bit", evt_status, 8'h02);
        rd(3'd2, v); chk("R8 dst held", v, 24'h20);
        rd(3'd4, v); chk("R8 cnt held wr", v, 24'd8);
        wr(3'd5, 24'hF);
    endtask

    task automatic t_locked;
        logic [23:0] v;
        setup(24'h000010, 24'h000020, 24'd8);
        wr(3'd0, 24'hF);
        wr(3'd1, 24'h000999);
        wr(3'd4, 24'd1);
        wr(3'd3, 24'h00);
        rd(3'd1, v); chk("R11 src locked", v, 24'h10);
        rd(3'd4, v); chk("R11 cnt locked", v, 24'd8);
        rd(3'd3, v); chk("R11 fc locked", v, 24'h52);
        wr(3'd0, 24'h0);
    endtask

    task automatic t_status;
        logic [23:0] v;
        dns_evt = 1'b1;
        @(negedge clk);
        dns_evt = 1'b0;
        chk("R9 ext bit", evt_status, 8'h08);
        setup(24'h000040, 24'h000080, 24'd1);
        wr(3'd0, 24'hF);
        bus_cyc(0); bus_cyc(0);
        chk("R10 two bits", evt_status, 8'h09);
        wr(3'd5, 24'h01);
        chk("R10 clear one", evt_status, 8'h08);
        wr(3'd5, 24'h00);
        chk("R10 zero write", evt_status, 8'h08);
        dns_evt = 1'b1;
        wr(3'd5, 24'h08);
        dns_evt = 1'b0;
        chk("R10 set wins", evt_status, 8'h08);
        wr(3'd5, 24'hFF);
        rd(3'd5, v); chk("R10 all clear", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fc_layout;
        t_word_copy;
        t_odd_start;
        t_wrap;
        t_bus_err;
        t_locked;
        t_status;
        t_full_count;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule